// File: doc/BRIEF.md
# SPI serial EEPROM word controller

This block is a hardware master for a byte-addressed SPI serial EEPROM. It presents the memory to a host as an array of 16-bit words. The host issues a single request with a word offset, a word count and a direction. Read words are returned over a valid/ready port, and write words are taken in over a second valid/ready port. The block drives chip select, the serial clock and MOSI, and samples MISO.

Before each command burst, the controller polls the device status until it is idle. A write is always preceded by a write-enable. A write burst is split wherever it reaches a device page boundary. Each request ends with a one-cycle completion pulse that carries an error bit.

Top module: `spi_eeprom_word_ctrl`

## Requirements
- R1: A request is rejected if its count is zero, its offset is at or beyond DEV_WORDS, or offset plus count exceeds DEV_WORDS. A rejected request produces a completion pulse with the error bit set, and chip select is never asserted for it.
- R2: Before each command burst, status opcode 0x05 is sent and 8 status bits are clocked in. This repeats until status bit 0 reads 0. Chip select is deasserted between successive polls and before the command that follows.
- R3: If status bit 0 is still 1 after RETRY_LIMIT polls, the request ends with the error bit set and no read or write opcode is sent.
- R4: A read sends opcode 0x03 once, followed by the byte address, which is twice the word offset. It then clocks in 16 bits per word without deasserting chip select, relying on the device's address auto-increment.
- R5: Words are byte-swapped on the serial line. The first byte received becomes bits 7:0 of a read word. Bits 7:0 of a write word are transmitted first.
- R6: With ADDR_BITS = 8, a read or write opcode whose starting word offset is 128 or more carries bit 3 (value 0x08) set as the ninth address bit.
- R7: Every write burst is preceded by opcode 0x06 in its own chip-select frame. It is then followed by opcode 0x02, the byte address, and the data words.
- R8: In a write burst, after each word the controller checks whether the next byte address (twice the next word offset) is a multiple of PAGE_BYTES. If it is and words remain, the burst ends. The controller then polls status again, sends a new write-enable, and opens a new write frame at that address.
- R9: Serial timing follows SPI mode 0. Bits go MSB first. SCK is low whenever chip select is deasserted. MOSI changes only while SCK is low. Each SCK half-period lasts cfg_div clock cycles, and a cfg_div of 0 counts as 1.
- R10: rd_valid holds with stable rd_data until rd_ready. wr_ready is high only while the controller waits for the next write word. SCK stays low while either port waits.
- R11: req_ready is high only when the controller is idle. done is a single-cycle pulse, and err is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | SCK half-period in clock cycles |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle, request accepted |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_offset | input | clog2(DEV_WORDS) | Starting word offset |
| req_count | input | clog2(DEV_WORDS)+1 | Number of words |
| wr_valid | input | 1 | Write word available |
| wr_ready | output | 1 | Controller takes the write word |
| wr_data | input | 16 | Write word |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Host takes the read word |
| rd_data | output | 16 | Read word |
| done | output | 1 | Request complete (one cycle) |
| err | output | 1 | Error status of the completed request |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bound checker watches the cycle-level rules on every cycle:
- SCK is held low while chip select is high.
- MOSI is frozen while SCK is high.
- The read port holds its word under back-pressure, and SCK is paused while either word port waits.
- done lasts one cycle and coincides with idle.

Protocol content can only be shown by the bench's scenarios, using a behavioural EEPROM that decodes the serial stream. This covers the status-poll counts, the retry abort, the ninth-address-bit opcode, the byte order, the write-enable before every write frame, and the splitting of bursts so that no page is crossed.

// File: rtl/spi_eeprom_word_ctrl.sv
module spi_eeprom_word_ctrl #(
  parameter int DEV_WORDS   = 256,
  parameter int ADDR_BITS   = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int RETRY_LIMIT = 8,
  parameter int DIV_W       = 8,
  localparam int OFS_W = $clog2(DEV_WORDS),
  localparam int CNT_W = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [CNT_W-1:0] req_count,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [15:0]      wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [15:0]      rd_data,
  output logic             done,
  output logic             err,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  localparam int TRY_W = $clog2(RETRY_LIMIT + 1);
  localparam int CMD_N = 8 + ADDR_BITS;
  localparam logic [23:0] ADDR_MASK = 24'((64'd1 << ADDR_BITS) - 64'd1);
  localparam logic [CNT_W:0] SIZE_X = (CNT_W+1)'(DEV_WORDS);
  localparam logic [7:0] OP_RDSR = 8'h05, OP_READ = 8'h03, OP_WRITE = 8'h02,
                         OP_WREN = 8'h06, OP_A8 = 8'h08;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_PCHK, S_CMD, S_WEN_END, S_WCMD, S_WWAIT,
    S_WNEXT, S_RDAT, S_RHOLD, S_SHIFT, S_GAP
  } st_t;

  st_t st, ret;
  logic [23:0]      sh_out;
  logic [15:0]      sh_in;
  logic [4:0]       nbits;
  logic [DIV_W-1:0] cnt;
  logic [TRY_W-1:0] tries;
  logic [CNT_W-1:0] cur, left;
  logic             is_wr, sck_q, cs_q, done_q, err_q;

  wire [CNT_W:0]     req_end  = (CNT_W+1)'(req_offset) + (CNT_W+1)'(req_count);
  wire               bad      = (req_count == '0) || ((CNT_W+1)'(req_offset) >= SIZE_X)
                                || (req_end > SIZE_X);
  wire [23:0]        baddr    = 24'(cur) << 1;
  wire               a8       = (ADDR_BITS == 8) && (24'(cur) >= 24'd128);
  wire               page_hit = (baddr % 24'(PAGE_BYTES)) == 24'd0;
  wire [7:0]         op_rw    = (is_wr ? OP_WRITE : OP_READ) | (a8 ? OP_A8 : 8'h00);
  wire [23:0]        cmd_word = (24'(op_rw) << ADDR_BITS) | (baddr & ADDR_MASK);
  wire [DIV_W-1:0]   div_eff  = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
  wire               tick     = (cnt == div_eff - DIV_W'(1));

  logic        ld;
  logic [23:0] ld_val;
  logic [4:0]  ld_n;
  st_t         ld_ret;

  always_comb begin
    ld = 1'b0; ld_val = '0; ld_n = 5'd0; ld_ret = S_IDLE;
    case (st)
      S_POLL:  begin ld = 1'b1; ld_val = {8'h00, OP_RDSR, 8'h00}; ld_n = 5'd16; ld_ret = S_PCHK; end
      S_CMD:   begin
        ld = 1'b1;
        if (is_wr) begin ld_val = 24'(OP_WREN); ld_n = 5'd8; ld_ret = S_WEN_END; end
        else       begin ld_val = cmd_word; ld_n = 5'(CMD_N); ld_ret = S_RDAT; end
      end
      S_WCMD:  begin ld = 1'b1; ld_val = cmd_word; ld_n = 5'(CMD_N); ld_ret = S_WWAIT; end
      S_WWAIT: begin ld = wr_valid; ld_val = {8'h00, wr_data[7:0], wr_data[15:8]}; ld_n = 5'd16; ld_ret = S_WNEXT; end
      S_RDAT:  begin ld = 1'b1; ld_n = 5'd16; ld_ret = S_RHOLD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret <= S_IDLE;
      sh_out <= '0; sh_in <= '0; nbits <= '0; cnt <= '0; tries <= '0;
      cur <= '0; left <= '0; is_wr <= 1'b0;
      sck_q <= 1'b0; cs_q <= 1'b1; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ld) begin
        sh_out <= ld_val << (5'd24 - ld_n);
        nbits  <= ld_n;
        ret    <= ld_ret;
        st     <= S_SHIFT;
        cs_q   <= 1'b0;
        cnt    <= '0;
        if (st == S_WWAIT) begin
          cur  <= cur + 1'b1;
          left <= left - 1'b1;
        end
      end else begin
        case (st)
          S_IDLE: if (req_valid) begin
            is_wr <= req_write;
            cur   <= CNT_W'(req_offset);
            left  <= req_count;
            tries <= '0;
            if (bad) begin done_q <= 1'b1; err_q <= 1'b1; end
            else st <= S_POLL;
          end
          S_PCHK: begin
            cs_q <= 1'b1;
            cnt  <= '0;
            if (!sh_in[0]) begin ret <= S_CMD; st <= S_GAP; end
            else if (tries == TRY_W'(RETRY_LIMIT - 1)) begin
              done_q <= 1'b1; err_q <= 1'b1; st <= S_IDLE;
            end else begin
              tries <= tries + 1'b1; ret <= S_POLL; st <= S_GAP;
            end
          end
          S_WEN_END: begin cs_q <= 1'b1; cnt <= '0; ret <= S_WCMD; st <= S_GAP; end
          S_WNEXT: begin
            if (left == '0) begin
              cs_q <= 1'b1; done_q <= 1'b1; err_q <= 1'b0; st <= S_IDLE;
            end else if (page_hit) begin
              cs_q <= 1'b1; cnt <= '0; tries <= '0; ret <= S_POLL; st <= S_GAP;
            end else st <= S_WWAIT;
          end
          S_RHOLD: if (rd_ready) begin
            left <= left - 1'b1;
            cur  <= cur + 1'b1;
            if (left == CNT_W'(1)) begin
              cs_q <= 1'b1; done_q <= 1'b1; err_q <= 1'b0; st <= S_IDLE;
            end else st <= S_RDAT;
          end
          S_GAP: if (tick) st <= ret; else cnt <= cnt + 1'b1;
          S_SHIFT: begin
            if (!tick) cnt <= cnt + 1'b1;
            else begin
              cnt <= '0;
              if (!sck_q) begin
                sck_q <= 1'b1;
                sh_in <= {sh_in[14:0], spi_miso};
              end else begin
                sck_q  <= 1'b0;
                sh_out <= sh_out << 1;
                nbits  <= nbits - 1'b1;
                if (nbits == 5'd1) st <= ret;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign req_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_WWAIT);
  assign rd_valid  = (st == S_RHOLD);
  assign rd_data   = {sh_in[7:0], sh_in[15:8]};
  assign done      = done_q;
  assign err       = err_q;
  assign spi_cs_n  = cs_q;
  assign spi_sck   = sck_q;
  assign spi_mosi  = (st == S_SHIFT) && sh_out[23];

endmodule

// File: rtl/spi_eeprom_word_ctrl_chk.sv
module spi_eeprom_word_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        done,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [15:0] rd_data,
  input logic        wr_ready,
  input logic        spi_cs_n,
  input logic        spi_sck,
  input logic        spi_mosi
);

  p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  p_mosi_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_rd_paused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!spi_sck && !spi_cs_n));

  p_wr_paused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!spi_sck && !spi_cs_n));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && spi_cs_n));

  p_ports_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, rd_valid, wr_ready}));

endmodule

bind spi_eeprom_word_ctrl spi_eeprom_word_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .wr_ready(wr_ready), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/spi_eeprom_word_ctrl_tb_top.sv
module spi_eeprom_word_ctrl_tb_top;

  localparam int BUSY_POLLS = 3;
  localparam int RETRIES    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = 8'd2;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_offset = '0;
  logic [8:0]  req_count = '0;
  logic        req_ready, wr_ready, rd_valid, done, err;
  logic        wr_valid = 1'b0, rd_ready = 1'b1;
  logic [15:0] wr_data = '0, rd_data;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;

  always #10 clk = ~clk;

  spi_eeprom_word_ctrl #(.RETRY_LIMIT(RETRIES)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_count(req_count),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .err(err),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int nchk = 0, nerr = 0;

  task automatic check(string rq, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // ---------------- behavioural EEPROM ----------------
  logic [7:0] mem [0:511];
  logic [7:0] rxb = '0, op = '0, tx = '0;
  logic [8:0] maddr = '0;
  logic [4:0] wpage = '0;
  int bitcnt = 0, wbytes = 0, busy = 0;
  bit wel = 1'b0, stuck = 1'b0;
  int nrdsr = 0, nwren = 0, nrd = 0, nwr = 0, bad_wel = 0, page_x = 0, ncs = 0;
  logic [7:0] last_rop = '0;
  logic [7:0] wop_log [$];

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    forever begin
      @(posedge spi_sck or posedge spi_cs_n);
      if (spi_cs_n) begin
        if (bitcnt >= 8 && op == 8'h05 && busy > 0) busy--;
        if (bitcnt >= 8 && (op & 8'hF7) == 8'h02 && wbytes > 0) begin
          busy = BUSY_POLLS; wel = 1'b0;
        end
        bitcnt = 0; wbytes = 0;
      end else begin
        rxb = {rxb[6:0], spi_mosi};
        bitcnt++;
        if (bitcnt % 8 == 0) begin
          tx = 8'h00;
          if (bitcnt == 8) begin
            op = rxb;
            case (op)
              8'h05: begin nrdsr++; tx = {6'b0, wel, (busy > 0) || stuck}; end
              8'h06: begin nwren++; wel = 1'b1; end
              8'h03, 8'h0B: begin nrd++; last_rop = op; end
              8'h02, 8'h0A: begin nwr++; wop_log.push_back(op); if (!wel) bad_wel++; end
              default: ;
            endcase
          end else if (bitcnt == 16) begin
            maddr = {op[3], rxb};
            wpage = maddr[8:4];
            if ((op & 8'hF7) == 8'h03) begin tx = mem[maddr]; maddr++; end
          end else begin
            if ((op & 8'hF7) == 8'h03) begin tx = mem[maddr]; maddr++; end
            else if ((op & 8'hF7) == 8'h02 && wel) begin
              if (maddr[8:4] != wpage) page_x++;
              mem[maddr] = rxb; maddr++; wbytes++;
            end
          end
        end
      end
    end
  end

  initial forever begin
    @(negedge spi_sck);
    if (!spi_cs_n) spi_miso = tx[3'(7 - (bitcnt % 8))];
  end

  initial forever begin
    @(negedge spi_cs_n);
    ncs++;
  end

  // ---------------- scoreboard: driver queues + monitor ----------------
  logic [15:0] exp_rd [$];
  logic [15:0] wq [$];
  bit stall = 1'b0;
  int cyc = 0, hirun = 0, bad_period = 0, npulse = 0;

  initial forever begin
    bit rf, wf;
    @(negedge clk);
    if (spi_sck) hirun++;
    else if (hirun > 0) begin
      if (hirun != ((cfg_div == 0) ? 1 : int'(cfg_div))) bad_period++;
      npulse++;
      hirun = 0;
    end
    rf = rd_valid && rd_ready;
    wf = wr_valid && wr_ready;
    if (rf) begin
      if (exp_rd.size() == 0) check("R4", "unexpected read word", int'(rd_data), 0);
      else check("R5", "read word", int'(rd_data), int'(exp_rd.pop_front()));
    end
    @(posedge clk);
    #1;
    if (wf) void'(wq.pop_front());
    wr_valid = (wq.size() > 0);
    wr_data  = (wq.size() > 0) ? wq[0] : 16'h0;
    cyc++;
    rd_ready = !stall || (cyc % 4 == 0);
  end

  function automatic logic [15:0] word_at(int w);
    return {mem[2*w+1], mem[2*w]};
  endfunction

  task automatic run_req(bit wr, int ofs, int cnt, output bit e, output bit busy_seen);
    bit got;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_offset = 8'(ofs); req_count = 9'(cnt);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    busy_seen = !req_ready;
    got = 1'b0;
    while (!got) begin
      @(negedge clk);
      if (done) begin got = 1'b1; e = err; end
    end
  endtask

  task automatic do_read(int ofs, int cnt, string rq);
    bit e, b;
    for (int k = 0; k < cnt; k++) exp_rd.push_back(word_at(ofs + k));
    run_req(1'b0, ofs, cnt, e, b);
    check(rq, "read err", int'(e), 0);
    check(rq, "read words left", exp_rd.size(), 0);
  endtask

  initial begin
    bit e, b;
    int s_rdsr, s_rd, s_wr, s_wren, s_cs;
    logic [15:0] wd [5];

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R11", "reset req_ready", int'(req_ready), 1);
    check("R11", "reset done", int'(done), 0);
    check("R9", "reset cs_n", int'(spi_cs_n), 1);
    check("R9", "reset sck", int'(spi_sck), 0);

    // R1 rejections
    s_cs = ncs;
    run_req(1'b0, 5, 0, e, b);
    check("R1", "count zero err", int'(e), 1);
    run_req(1'b1, 250, 7, e, b);
    check("R1", "overrun err", int'(e), 1);
    check("R1", "no chip select", ncs - s_cs, 0);

    // R2 R4 R5 plain read
    s_rdsr = nrdsr; s_rd = nrd;
    run_req(1'b0, 0, 0, e, b);
    do_read(10, 3, "R4");
    check("R2", "polls idle device", nrdsr - s_rdsr, 1);
    check("R4", "one read opcode", nrd - s_rd, 1);

    // R6 ninth address bit
    do_read(127, 2, "R6");
    check("R6", "opcode below 128", int'(last_rop), 8'h03);
    do_read(200, 2, "R6");
    check("R6", "opcode at 200", int'(last_rop), 8'h0B);

    // R10 back-pressure, R1 exact fit at end
    stall = 1'b1;
    do_read(250, 6, "R10");
    stall = 1'b0;

    // R7 R8 write crossing one page boundary
    for (int k = 0; k < 5; k++) begin wd[k] = 16'(16'h1357 * (k + 3)); wq.push_back(wd[k]); end
    s_rdsr = nrdsr; s_wr = nwr; s_wren = nwren;
    wop_log.delete();
    run_req(1'b1, 6, 5, e, b);
    check("R11", "busy while writing", int'(b), 1);
    check("R7", "write err", int'(e), 0);
    check("R8", "write frames", nwr - s_wr, 2);
    check("R7", "write enables", nwren - s_wren, 2);
    check("R7", "write without enable", bad_wel, 0);
    check("R8", "page crossings", page_x, 0);
    check("R8", "polls incl. re-poll", nrdsr - s_rdsr, 1 + BUSY_POLLS + 1);
    for (int k = 0; k < 5; k++) begin
      check("R5", "low byte first", int'(mem[2*(6+k)]), int'(wd[k][7:0]));
      check("R5", "high byte second", int'(mem[2*(6+k)+1]), int'(wd[k][15:8]));
    end
    s_rdsr = nrdsr;
    do_read(6, 5, "R7");
    check("R2", "polls after write", nrdsr - s_rdsr, BUSY_POLLS + 1);

    // R6 R8 write across the 128 boundary
    wq.push_back(16'hBEEF); wq.push_back(16'hC0DE);
    s_wr = nwr;
    wop_log.delete();
    run_req(1'b1, 127, 2, e, b);
    check("R8", "frames across 128", nwr - s_wr, 2);
    check("R6", "first write opcode", int'(wop_log[0]), 8'h02);
    check("R6", "second write opcode", int'(wop_log[1]), 8'h0A);
    check("R8", "page crossings", page_x, 0);
    do_read(127, 2, "R6");

    // R3 retry limit
    stuck = 1'b1;
    s_rdsr = nrdsr; s_rd = nrd; s_wr = nwr;
    run_req(1'b0, 3, 1, e, b);
    check("R3", "timeout err", int'(e), 1);
    check("R3", "polls at limit", nrdsr - s_rdsr, RETRIES);
    check("R3", "no command sent", (nrd - s_rd) + (nwr - s_wr), 0);
    stuck = 1'b0;
    run_req(1'b0, 0, 0, e, b);
    exp_rd.delete();

    // R9 divider settings
    cfg_div = 8'd3;
    do_read(0, 1, "R9");
    cfg_div = 8'd0;
    do_read(1, 2, "R9");
    cfg_div = 8'd2;
    check("R9", "half-period mismatches", bad_period, 0);
    check("R9", "sck pulses seen", int'(npulse > 0), 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule